// File: doc/BRIEF.md
# Directory Shared-Line Buffer

This block is a small fully associative store of data lines that sits beside a tile's coherence directory. When several cores are reading the same clean line, the directory can park a copy here and answer further reads itself, rather than forwarding each read to whichever cache holds the line. The buffer keeps four 64-byte lines (256 bytes of data) with their addresses.

The directory offers a candidate line on the insert port together with its address, its clean flag and the number of cores currently reading it. Whether the candidate is taken depends on a mode input. In the strict mode a clean line needs at least three concurrent readers. In the all-shared mode any clean line with two or more readers is taken. A read probe on the lookup port returns a registered hit flag and the line one cycle later. When a write to a line is seen, the invalidate port drops that line so the next read goes back through the normal coherence path. A full buffer replaces its least recently used entry.

Top module: `shared_line_buffer`

## Requirements
- R1: After a synchronous active-high reset the buffer holds no lines, so every lookup reports a miss.
- R2: With `mode_all_shared` at 0, a clean insert is stored only when `ins_readers` is 3 or more; a clean insert with 2 readers leaves the buffer unchanged.
- R3: With `mode_all_shared` at 1, a clean insert with 2 or more readers is stored; one with fewer than 2 readers leaves the buffer unchanged.
- R4: An insert with `ins_clean` at 0 is never stored, whatever the mode or reader count.
- R5: `lk_hit` and `lk_data` are registered: they reflect a lookup one clock edge after `lk_valid` is sampled high, and `lk_hit` is 0 after any edge at which `lk_valid` was low.
- R6: An accepted insert whose address is already held overwrites that entry's data in place and takes no new entry.
- R7: With all entries valid, an accepted insert of a new address replaces the least recently used entry, where an entry is used when it is inserted, updated, or hit by a lookup (an insert in the same cycle takes precedence over the lookup for recency). An insert into a buffer with a free entry never evicts.
- R8: An invalidate removes the matching entry at that clock edge; a lookup of the same address in the same cycle reports a miss, and later lookups miss too.
- R9: An insert and an invalidate of the same address in the same cycle leave that address absent from the buffer.
- R10: A lookup in the same cycle as an insert sees the buffer as it stood before the insert: a new address misses, and an updated address returns its old data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_all_shared | input | 1 | 0: admit at 3+ readers; 1: admit any read-shared (2+ readers) line |
| ins_valid | input | 1 | Insert request |
| ins_addr | input | ADDR_W | Line address of the candidate |
| ins_data | input | LINE_BYTES*8 | Line data of the candidate |
| ins_readers | input | RDR_W | Current number of concurrent readers |
| ins_clean | input | 1 | Candidate line is clean |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup address |
| inv_valid | input | 1 | Invalidate request (write seen) |
| inv_addr | input | ADDR_W | Address to invalidate |
| lk_hit | output | 1 | Registered hit for the previous cycle's lookup |
| lk_data | output | LINE_BYTES*8 | Registered line data, meaningful when `lk_hit` is 1 |

## Verification
Inserts and invalidates change the stored state at the edge where they are sampled, and a lookup result is due exactly one edge after its request, so the bench drives every request on the falling clock edge, lets one rising edge pass and reads `lk_hit` and `lk_data` just after it. Effects of an insert or invalidate are therefore seen through a lookup issued in a later cycle, while the same-cycle orderings of R8, R9 and R10 are checked by combining requests in a single cycle and reading the result after that one edge. Replacement order is checked by tracking the recency sequence of inserts and hits in the bench and probing which address disappeared.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  typedef enum logic {
    MODE_STRICT     = 1'b0,
    MODE_ALL_SHARED = 1'b1
  } sbuf_mode_e;

  // reader count from which a line counts as read-shared
  localparam int SBUF_SHARED_MIN = 2;
endpackage

// File: rtl/sbuf_tag_match.sv
module sbuf_tag_match #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 32
) (
  input  logic [ADDR_W-1:0]  tags [ENTRIES],
  input  logic [ENTRIES-1:0] valid,
  input  logic [ADDR_W-1:0]  key,
  output logic [ENTRIES-1:0] match
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end
endmodule

// File: rtl/sbuf_lru.sv
module sbuf_lru #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] valid,
  output logic [IDX_W-1:0]   victim_idx
);
  // ages form a permutation of 0..ENTRIES-1; 0 is most recent
  logic [IDX_W-1:0] age_q [ENTRIES];

  always_comb begin
    logic found;
    found      = 1'b0;
    victim_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid[i] && !found) begin
        victim_idx = IDX_W'(i);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (age_q[i] == IDX_W'(ENTRIES - 1)) victim_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)          age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbuf_line_store.sv
module sbuf_line_store #(
  parameter int ENTRIES = 4,
  parameter int DATA_W  = 512,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [ENTRIES];

  // read-first single-clock memory, inferable as block RAM
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
    if (wr_en) mem[wr_idx] <= wr_data;
  end
endmodule

// File: rtl/shared_line_buffer.sv
module shared_line_buffer #(
  parameter int ENTRIES     = 4,
  parameter int LINE_BYTES  = 64,
  parameter int ADDR_W      = 32,
  parameter int RDR_W       = 6,
  parameter int MIN_READERS = 3,
  localparam int DATA_W     = LINE_BYTES * 8,
  localparam int IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_all_shared,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [DATA_W-1:0] ins_data,
  input  logic [RDR_W-1:0]  ins_readers,
  input  logic              ins_clean,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data
);
  import sbuf_pkg::*;

  logic [ENTRIES-1:0] valid_q;
  logic [ADDR_W-1:0]  tag_q [ENTRIES];
  logic [ENTRIES-1:0] lk_match, ins_match, inv_match;
  logic [IDX_W-1:0]   lk_idx, ins_idx, victim_idx, wr_idx, touch_idx;
  logic [RDR_W-1:0]   admit_thr;
  logic               do_ins, lk_kill, lk_found, touch_en;

  sbuf_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match_lk (
    .tags(tag_q), .valid(valid_q), .key(lk_addr), .match(lk_match));
  sbuf_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match_ins (
    .tags(tag_q), .valid(valid_q), .key(ins_addr), .match(ins_match));
  sbuf_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match_inv (
    .tags(tag_q), .valid(valid_q), .key(inv_addr), .match(inv_match));

  always_comb begin
    lk_idx  = '0;
    ins_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i])  lk_idx  = IDX_W'(i);
      if (ins_match[i]) ins_idx = IDX_W'(i);
    end
  end

  // admission policy
  assign admit_thr = (mode_all_shared == MODE_ALL_SHARED) ? RDR_W'(SBUF_SHARED_MIN)
                                                          : RDR_W'(MIN_READERS);
  assign do_ins = ins_valid && ins_clean && (ins_readers >= admit_thr)
               && !(inv_valid && (inv_addr == ins_addr));
  assign wr_idx = (|ins_match) ? ins_idx : victim_idx;

  assign lk_kill  = inv_valid && (inv_addr == lk_addr);
  assign lk_found = lk_valid && (|lk_match) && !lk_kill;

  assign touch_en  = do_ins || lk_found;
  assign touch_idx = do_ins ? wr_idx : lk_idx;

  sbuf_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst(rst), .touch_en(touch_en), .touch_idx(touch_idx),
    .valid(valid_q), .victim_idx(victim_idx));

  sbuf_line_store #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_store (
    .clk(clk), .wr_en(do_ins), .wr_idx(wr_idx), .wr_data(ins_data),
    .rd_en(lk_valid), .rd_idx(lk_idx), .rd_data(lk_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '0;
    end else begin
      if (inv_valid) valid_q <= valid_q & ~inv_match;
      if (do_ins) begin
        valid_q[wr_idx] <= 1'b1;
        tag_q[wr_idx]   <= ins_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lk_hit <= 1'b0;
    else     lk_hit <= lk_found;
  end
endmodule

// File: rtl/shared_line_buffer_chk.sv
module shared_line_buffer_chk #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               ins_valid,
  input logic               ins_clean,
  input logic               lk_valid,
  input logic [ADDR_W-1:0]  lk_addr,
  input logic               inv_valid,
  input logic [ADDR_W-1:0]  inv_addr,
  input logic               lk_hit,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] lk_match
);
  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (valid_vec == '0));

  a_r5_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !lk_hit);

  a_r8_inv_same_cycle_miss: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && inv_valid && (lk_addr == inv_addr)) |=> !lk_hit);

  a_r6_no_duplicate: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  a_r4_dirty_ignored: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !ins_clean && !inv_valid) |=> $stable(valid_vec));

  a_r8_inv_never_grows: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && !ins_valid) |=> ($countones(valid_vec) <= $countones($past(valid_vec))));
endmodule

bind shared_line_buffer shared_line_buffer_chk #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_clean(ins_clean),
  .lk_valid(lk_valid), .lk_addr(lk_addr), .inv_valid(inv_valid), .inv_addr(inv_addr),
  .lk_hit(lk_hit), .valid_vec(valid_q), .lk_match(lk_match));

// File: tb/test_shared_line_buffer.sv
module test_shared_line_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int RDR_W  = 6;
  localparam int DATA_W = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_all_shared = 1'b0;
  logic ins_valid = 1'b0, ins_clean = 1'b0, lk_valid = 1'b0, inv_valid = 1'b0;
  logic [ADDR_W-1:0] ins_addr = '0, lk_addr = '0, inv_addr = '0;
  logic [DATA_W-1:0] ins_data = '0;
  logic [RDR_W-1:0]  ins_readers = '0;
  logic              lk_hit;
  logic [DATA_W-1:0] lk_data;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_line_buffer i_shared_line_buffer (
    .clk(clk), .rst(rst), .mode_all_shared(mode_all_shared),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_data(ins_data),
    .ins_readers(ins_readers), .ins_clean(ins_clean),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .inv_valid(inv_valid), .inv_addr(inv_addr),
    .lk_hit(lk_hit), .lk_data(lk_data));

  function automatic logic [DATA_W-1:0] line_of(input logic [31:0] s);
    return {16{s ^ 32'h5A3C_0000}};
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_data(input string req, input logic [DATA_W-1:0] act,
                            input logic [DATA_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act[31:0], exp[31:0]);
    end
  endtask

  task automatic begin_cycle();
    @(negedge clk);
  endtask

  task automatic end_cycle();
    @(posedge clk);
    #1;
    ins_valid = 1'b0;
    lk_valid  = 1'b0;
    inv_valid = 1'b0;
  endtask

  task automatic set_ins(input logic [31:0] a, input logic [31:0] seed,
                         input int rd, input logic cl);
    ins_valid   = 1'b1;
    ins_addr    = a;
    ins_data    = line_of(seed);
    ins_readers = RDR_W'(rd);
    ins_clean   = cl;
  endtask

  task automatic insert(input logic [31:0] a, input logic [31:0] seed,
                        input int rd, input logic cl);
    begin_cycle();
    set_ins(a, seed, rd, cl);
    end_cycle();
  endtask

  task automatic lookup(input string req, input logic [31:0] a,
                        input logic exp_hit, input logic [31:0] seed);
    begin_cycle();
    lk_valid = 1'b1;
    lk_addr  = a;
    end_cycle();
    check_bit(req, lk_hit, exp_hit);
    if (exp_hit) check_data(req, lk_data, line_of(seed));
  endtask

  task automatic do_reset();
    begin_cycle();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    lookup("R1", 32'h0, 1'b0, 0);
    lookup("R1", 32'h40, 1'b0, 0);
    begin_cycle();
    end_cycle();
    check_bit("R5 idle", lk_hit, 1'b0);
  endtask

  task automatic t_strict_mode();
    do_reset();
    mode_all_shared = 1'b0;
    insert(32'h100, 32'h11, 2, 1'b1);
    lookup("R2 two readers rejected", 32'h100, 1'b0, 0);
    insert(32'h100, 32'h12, 3, 1'b1);
    lookup("R2 three readers admitted", 32'h100, 1'b1, 32'h12);
    insert(32'h140, 32'h13, 9, 1'b0);
    lookup("R4 dirty rejected strict", 32'h140, 1'b0, 0);
    begin_cycle();
    end_cycle();
    check_bit("R5 hit drops without lookup", lk_hit, 1'b0);
  endtask

  task automatic t_all_shared_mode();
    do_reset();
    mode_all_shared = 1'b1;
    insert(32'h200, 32'h21, 1, 1'b1);
    lookup("R3 one reader rejected", 32'h200, 1'b0, 0);
    insert(32'h200, 32'h22, 2, 1'b1);
    lookup("R3 two readers admitted", 32'h200, 1'b1, 32'h22);
    insert(32'h240, 32'h23, 5, 1'b0);
    lookup("R4 dirty rejected all-shared", 32'h240, 1'b0, 0);
    mode_all_shared = 1'b0;
  endtask

  task automatic t_update_in_place();
    do_reset();
    insert(32'hA0, 32'hA1, 3, 1'b1);
    insert(32'hB0, 32'hB1, 3, 1'b1);
    insert(32'hC0, 32'hC1, 3, 1'b1);
    insert(32'hA0, 32'hA2, 4, 1'b1);  // update; order now B,C,A (oldest first)
    insert(32'hD0, 32'hD1, 3, 1'b1);  // takes the free slot
    lookup("R6 B kept", 32'hB0, 1'b1, 32'hB1);
    lookup("R6 updated data", 32'hA0, 1'b1, 32'hA2);
    lookup("R6 C kept", 32'hC0, 1'b1, 32'hC1);
    lookup("R6 D stored", 32'hD0, 1'b1, 32'hD1);
  endtask

  task automatic t_lru();
    do_reset();
    insert(32'h10, 32'h1, 3, 1'b1);
    insert(32'h20, 32'h2, 3, 1'b1);
    insert(32'h30, 32'h3, 3, 1'b1);
    insert(32'h40, 32'h4, 3, 1'b1);
    lookup("R7 hit refreshes", 32'h10, 1'b1, 32'h1);  // oldest now 0x20
    insert(32'h50, 32'h5, 3, 1'b1);
    lookup("R7 LRU evicted", 32'h20, 1'b0, 0);
    lookup("R7 refreshed kept", 32'h10, 1'b1, 32'h1);
    lookup("R7 kept", 32'h30, 1'b1, 32'h3);
    lookup("R7 kept", 32'h40, 1'b1, 32'h4);
    lookup("R7 new entry", 32'h50, 1'b1, 32'h5);
    // recency now 0x50 oldest? order oldest first: 0x50? no: 10,30,40,50 touched in that order
    insert(32'h60, 32'h6, 3, 1'b1);
    lookup("R7 second eviction", 32'h10, 1'b0, 0);
  endtask

  task automatic t_invalidate();
    do_reset();
    insert(32'h300, 32'h31, 3, 1'b1);
    insert(32'h340, 32'h34, 3, 1'b1);
    begin_cycle();
    lk_valid = 1'b1; lk_addr = 32'h300;
    inv_valid = 1'b1; inv_addr = 32'h340;
    end_cycle();
    check_bit("R8 other address unaffected", lk_hit, 1'b1);
    check_data("R8 other address data", lk_data, line_of(32'h31));
    begin_cycle();
    lk_valid = 1'b1; lk_addr = 32'h300;
    inv_valid = 1'b1; inv_addr = 32'h300;
    end_cycle();
    check_bit("R8 same-cycle miss", lk_hit, 1'b0);
    lookup("R8 removed", 32'h300, 1'b0, 0);
    lookup("R8 removed earlier", 32'h340, 1'b0, 0);
  endtask

  task automatic t_same_cycle();
    do_reset();
    begin_cycle();
    set_ins(32'h400, 32'h41, 3, 1'b1);
    inv_valid = 1'b1; inv_addr = 32'h400;
    end_cycle();
    lookup("R9 insert dropped", 32'h400, 1'b0, 0);
    begin_cycle();
    set_ins(32'h500, 32'h51, 3, 1'b1);
    lk_valid = 1'b1; lk_addr = 32'h500;
    end_cycle();
    check_bit("R10 new address misses", lk_hit, 1'b0);
    lookup("R10 stored after", 32'h500, 1'b1, 32'h51);
    begin_cycle();
    set_ins(32'h500, 32'h52, 3, 1'b1);
    lk_valid = 1'b1; lk_addr = 32'h500;
    end_cycle();
    check_bit("R10 update hit", lk_hit, 1'b1);
    check_data("R10 old data", lk_data, line_of(32'h51));
    lookup("R10 new data after", 32'h500, 1'b1, 32'h52);
  endtask

  initial begin
    t_reset();
    t_strict_mode();
    t_all_shared_mode();
    t_update_in_place();
    t_lru();
    t_invalidate();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule